// File: doc/BRIEF.md
# ALU Status Flag Generator

This block performs one arithmetic, logic or single-bit shift operation per accepted request on 8-bit or 16-bit operands. It produces the result together with the six arithmetic status indicators: carry/borrow, nibble carry, zero, sign, even parity and signed overflow. The indicators are kept in a 16-bit flag register, which also holds three control flags (trap, interrupt enable, direction). Software-visible logic writes those three flags through plain strobes, and no arithmetic operation ever changes them.

Operation requests enter on a valid/ready channel. A request is taken on a rising clock edge where `op_valid` and `op_ready` are both high. `op_ready` is high whenever the one-entry result register is empty or is being drained in the same cycle (`!res_valid || res_ready`). A result is presented with `res_valid` on the cycle after acceptance. While `res_valid` is high and `res_ready` is low, the result stays unchanged and no new request is taken. The flag register changes only on an accepted request or on a control-flag strobe. Its new value is visible on `flags` in the same cycle as the result.

The width select picks the bit used for sign, carry and overflow (bit 7 or bit 15). Parity always looks at the low byte of the result.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset (`rst_n` low), `flags` reads 16'h0002, `res_valid` is 0 and `res_data` is 0.
- R2: The flag layout is carry=bit 0, parity=bit 2, nibble carry=bit 4, zero=bit 6, sign=bit 7, trap=bit 8, interrupt enable=bit 9, direction=bit 10, overflow=bit 11. Bit 1 always reads 1, and bits 3, 5 and 12–15 always read 0.
- R3: `op_code` 0=ADD, 1=ADD with carry, 2=SUB, 3=SUB with borrow. Only codes 1 and 3 use `carry_in`. The carry flag is set on an unsigned carry out of the top bit for codes 0/1 and on a borrow out of the top bit for codes 2/3.
- R4: For codes 0–3, the nibble-carry flag is set on a carry (add) or borrow (subtract) out of bit 3.
- R5: `op_wide`=1 selects 16 bits and `op_wide`=0 selects 8 bits. In byte mode only the low 8 operand bits are used and `res_data[15:8]` is 0. The zero flag is set when the width-masked result is 0. The sign flag copies result bit 7 (byte) or bit 15 (word).
- R6: The parity flag is set when `res_data[7:0]` holds an even number of ones, in both widths, for codes 0–9.
- R7: For codes 0–3, the overflow flag is set when the exact signed result lies outside the signed range of the selected width.
- R8: Codes 4=AND, 5=OR, 6=XOR clear the carry and overflow flags, update zero, sign and parity, and leave the nibble-carry flag unchanged.
- R9: Codes 7=shift left, 8=logical shift right and 9=arithmetic shift right shift `opnd_a` by one bit and ignore `opnd_b`. The carry flag receives the bit shifted out. Overflow is (new top bit XOR carry) for code 7, the original top bit for code 8, and 0 for code 9. Zero, sign and parity are updated, and nibble carry is unchanged.
- R10: `ctl_wr[i]` loads `ctl_val[i]` into flag bit 8+i on the next edge (i=0 trap, 1 interrupt enable, 2 direction). No operation changes these bits.
- R11: With `res_valid`=1 and `res_ready`=0, `op_ready` is 0. A presented request is then not taken: `res_data` and the status bits of `flags` hold until the result is drained.
- R12: Codes 10–15 return `opnd_a` masked to the selected width and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation request present |
| op_ready | output | 1 | Request can be taken this cycle |
| op_code | input | 4 | Operation code (see R3, R8, R9, R12) |
| op_wide | input | 1 | 1 = 16-bit, 0 = 8-bit operation |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry/borrow input for codes 1 and 3 |
| ctl_wr | input | 3 | Per-bit write strobes for the control flags |
| ctl_val | input | 3 | Values for the control flags |
| res_valid | output | 1 | Result register holds a result |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 16 | Operation result |
| flags | output | 16 | Packed flag register |

## Verification
The four arithmetic codes are swept in byte mode over a strided grid of both operands, with the carry input alternating. All pairs of boundary values (0, 1, 0x0F, 0x10, the signed extremes, all ones) are run in both widths. Together these separate carry from borrow, bit-3 carry from bit-7/15 carry, and signed from unsigned overflow. Word mode adds pseudo-random operand pairs, which show that sign and overflow follow bit 15 while parity stays on the low byte. Logic and shift codes run with a nibble-carry value left behind by an earlier addition, which shows that this flag survives them. A stalled result channel, control-flag strobes and an unused code check the hold, the register separation and the no-change cases.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int NUM_W  = 2;
  localparam int OPC_W  = 4;
  localparam int CTL_N  = 3;

  localparam int CF_BIT = 0;
  localparam int PF_BIT = 2;
  localparam int AF_BIT = 4;
  localparam int ZF_BIT = 6;
  localparam int SF_BIT = 7;
  localparam int TF_BIT = 8;
  localparam int OF_BIT = 11;

  localparam logic [WORD_W-1:0] FIXED_ONES = 16'h0002;
  localparam logic [WORD_W-1:0] LIVE_MASK  = 16'h0FD5;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_SHL = 4'd7,
    OP_SHR = 4'd8,
    OP_SAR = 4'd9
  } opc_e;

  typedef enum logic [1:0] {
    CLS_NONE,
    CLS_ARITH,
    CLS_LOGIC,
    CLS_SHIFT
  } opcls_e;

  function automatic opcls_e classify(input logic [OPC_W-1:0] code);
    opcls_e c;
    if (code <= 4'd3)      c = CLS_ARITH;
    else if (code <= 4'd6) c = CLS_LOGIC;
    else if (code <= 4'd9) c = CLS_SHIFT;
    else                   c = CLS_NONE;
    return c;
  endfunction
endpackage

// File: rtl/alu_arith_core.sv
module alu_arith_core
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         use_cin,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cf,
  output logic         af,
  output logic         of
);
  localparam int NW = NIB_W;

  logic [W-1:0]  b_x;
  logic          c_x;
  logic [W:0]    full;
  logic [NW:0]   nib;

  // Subtraction is a + ~b + (1 - borrow); carry out inverts into borrow.
  always_comb begin
    b_x  = sub ? ~b : b;
    c_x  = sub ^ (use_cin & cin);
    full = {1'b0, a} + {1'b0, b_x} + {{W{1'b0}}, c_x};
    nib  = {1'b0, a[NW-1:0]} + {1'b0, b_x[NW-1:0]} + {{NW{1'b0}}, c_x};
    sum  = full[W-1:0];
    cf   = full[W] ^ sub;
    af   = nib[NW] ^ sub;
    of   = (a[W-1] == b_x[W-1]) && (sum[W-1] != a[W-1]);
  end

  // R3: adding zero without carry in can never carry out
  always_comb begin
    if (!sub && !use_cin && (b == '0)) begin
      a_r3_add_zero_no_carry: assert (!cf);
    end
  end

  // R4: subtracting zero without borrow in can never borrow from bit 3
  always_comb begin
    if (sub && !use_cin && (b == '0)) begin
      a_r4_sub_zero_no_nibble_borrow: assert (!af);
    end
  end
endmodule

// File: rtl/alu_logic_core.sv
module alu_logic_core
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  opc_e         op,
  output logic [W-1:0] res,
  output logic         cf,
  output logic         of
);
  always_comb begin
    res = a;
    cf  = 1'b0;
    of  = 1'b0;
    unique case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_SHL: begin
        res = {a[W-2:0], 1'b0};
        cf  = a[W-1];
        of  = a[W-1] ^ a[W-2];
      end
      OP_SHR: begin
        res = {1'b0, a[W-1:1]};
        cf  = a[0];
        of  = a[W-1];
      end
      OP_SAR: begin
        res = {a[W-1], a[W-1:1]};
        cf  = a[0];
        of  = 1'b0;
      end
      default: res = a;
    endcase
  end

  // R9: arithmetic right shift keeps the sign bit
  always_comb begin
    if (op == OP_SAR) begin
      a_r9_sar_sign_kept: assert (res[W-1] == a[W-1]);
    end
  end
endmodule

// File: rtl/alu_status_eval.sv
module alu_status_eval
  import alu_flag_pkg::*;
(
  input  logic [WORD_W-1:0] res,
  input  logic              wide,
  output logic              zf,
  output logic              sf,
  output logic              pf
);
  logic [BYTE_W-1:0] low_b;

  always_comb begin
    low_b = res[BYTE_W-1:0];
    zf    = wide ? (res == '0) : (low_b == '0);
    sf    = wide ? res[WORD_W-1] : res[BYTE_W-1];
    pf    = ~(^low_b);
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  output logic        op_ready,
  input  logic [3:0]  op_code,
  input  logic        op_wide,
  input  logic [15:0] opnd_a,
  input  logic [15:0] opnd_b,
  input  logic        carry_in,
  input  logic [2:0]  ctl_wr,
  input  logic [2:0]  ctl_val,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [15:0] res_data,
  output logic [15:0] flags
);
  opc_e   opc;
  opcls_e cls;
  logic   accept;
  logic   is_sub;
  logic   use_cin;

  logic [WORD_W-1:0] ar_res [NUM_W];
  logic [WORD_W-1:0] lg_res [NUM_W];
  logic [NUM_W-1:0]  ar_cf, ar_af, ar_of;
  logic [NUM_W-1:0]  lg_cf, lg_of;

  logic [WORD_W-1:0] res_n;
  logic              zf_n, sf_n, pf_n;
  logic [WORD_W-1:0] flag_q, flag_n;
  logic [WORD_W-1:0] res_q;
  logic              vld_q;

  always_comb begin
    opc     = opc_e'(op_code);
    cls     = classify(op_code);
    is_sub  = (opc == OP_SUB) || (opc == OP_SBB);
    use_cin = (opc == OP_ADC) || (opc == OP_SBB);
  end

  assign op_ready = !vld_q || res_ready;
  assign accept   = op_valid && op_ready;

  // One lane per width: lane 0 byte, lane 1 word
  for (genvar g = 0; g < NUM_W; g++) begin : g_lane
    localparam int W = BYTE_W << g;
    logic [W-1:0] l_sum, l_lres;
    logic         l_cf, l_af, l_of, l_lcf, l_lof;

    alu_arith_core #(.W(W)) u_arith (
      .a       (opnd_a[W-1:0]),
      .b       (opnd_b[W-1:0]),
      .sub     (is_sub),
      .use_cin (use_cin),
      .cin     (carry_in),
      .sum     (l_sum),
      .cf      (l_cf),
      .af      (l_af),
      .of      (l_of)
    );

    alu_logic_core #(.W(W)) u_logic (
      .a   (opnd_a[W-1:0]),
      .b   (opnd_b[W-1:0]),
      .op  (opc),
      .res (l_lres),
      .cf  (l_lcf),
      .of  (l_lof)
    );

    assign ar_res[g] = WORD_W'(l_sum);
    assign lg_res[g] = WORD_W'(l_lres);
    assign ar_cf[g]  = l_cf;
    assign ar_af[g]  = l_af;
    assign ar_of[g]  = l_of;
    assign lg_cf[g]  = l_lcf;
    assign lg_of[g]  = l_lof;
  end

  always_comb begin
    if (cls == CLS_ARITH) res_n = ar_res[op_wide];
    else                  res_n = lg_res[op_wide];
  end

  alu_status_eval u_eval (
    .res  (res_n),
    .wide (op_wide),
    .zf   (zf_n),
    .sf   (sf_n),
    .pf   (pf_n)
  );

  always_comb begin
    flag_n = flag_q;
    if (accept) begin
      unique case (cls)
        CLS_ARITH: begin
          flag_n[CF_BIT] = ar_cf[op_wide];
          flag_n[AF_BIT] = ar_af[op_wide];
          flag_n[OF_BIT] = ar_of[op_wide];
          flag_n[ZF_BIT] = zf_n;
          flag_n[SF_BIT] = sf_n;
          flag_n[PF_BIT] = pf_n;
        end
        CLS_LOGIC, CLS_SHIFT: begin
          flag_n[CF_BIT] = lg_cf[op_wide];
          flag_n[OF_BIT] = lg_of[op_wide];
          flag_n[ZF_BIT] = zf_n;
          flag_n[SF_BIT] = sf_n;
          flag_n[PF_BIT] = pf_n;
        end
        default: flag_n = flag_q;
      endcase
    end
    for (int i = 0; i < CTL_N; i++) begin
      if (ctl_wr[i]) flag_n[TF_BIT+i] = ctl_val[i];
    end
    flag_n = (flag_n & LIVE_MASK) | FIXED_ONES;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= FIXED_ONES;
      res_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      if (accept) begin
        res_q <= res_n;
        vld_q <= 1'b1;
      end else if (res_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign res_valid = vld_q;
  assign res_data  = res_q;
  assign flags     = flag_q;

  // R11: a stalled result stays valid and unchanged
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R11: no accepted request and no strobe leaves the flags alone
  a_r11_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!(op_valid && op_ready) && (ctl_wr == '0)) |=> $stable(flags));

  // R10: operations never touch the control flags
  a_r10_ctl_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr == '0) |=> $stable(flags[TF_BIT+CTL_N-1:TF_BIT]));

  // R8: logic codes clear carry and overflow
  a_r8_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (classify(op_code) == CLS_LOGIC)) |=> (!flags[CF_BIT] && !flags[OF_BIT]));

  // R8 and R9: logic and shift keep the nibble carry
  a_r8_af_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ((classify(op_code) == CLS_LOGIC) || (classify(op_code) == CLS_SHIFT)))
      |=> $stable(flags[AF_BIT]));

  // R9: logical right shift moves bit 0 into carry
  a_r9_shr_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op_code == 4'd8)) |=> (flags[CF_BIT] == $past(opnd_a[0])));

  // R5: byte operations leave the upper result byte clear
  a_r5_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !op_wide) |=> (res_data[15:8] == 8'h00));

  // R2: fixed bits never move
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~LIVE_MASK) == FIXED_ONES));
endmodule

// File: tb/alu_flag_unit_test.sv
`timescale 1ns/1ps
module alu_flag_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [3:0]  op_code = 4'd0;
  logic        op_wide = 1'b0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic        carry_in = 1'b0;
  logic [2:0]  ctl_wr = '0;
  logic [2:0]  ctl_val = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_data;
  logic [15:0] flags;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_flags = 16'h0002;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  alu_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_wide(op_wide), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .carry_in(carry_in), .ctl_wr(ctl_wr), .ctl_val(ctl_val),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .flags(flags)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // Arithmetic reference; updates exp_flags, returns expected result
  function automatic int model(input int op, input bit wide, input int a, input int b, input bit c);
    int w, m, av, bv, sa, sb, r, sr, ci, lo, hi, ones;
    bit cf, af, of, arith, upd;
    w  = wide ? 16 : 8;
    m  = (1 << w) - 1;
    av = a & m;
    bv = b & m;
    sa = (av >= (1 << (w - 1))) ? av - (1 << w) : av;
    sb = (bv >= (1 << (w - 1))) ? bv - (1 << w) : bv;
    lo = -(1 << (w - 1));
    hi = (1 << (w - 1)) - 1;
    ci = (op == 1 || op == 3) ? int'(c) : 0;
    arith = 1'b0; upd = 1'b1; cf = 1'b0; af = 1'b0; of = 1'b0; r = av;
    case (op)
      0, 1: begin
        r = (av + bv + ci) & m; cf = (av + bv + ci) > m;
        af = ((av & 15) + (bv & 15) + ci) > 15;
        sr = sa + sb + ci; of = (sr > hi) || (sr < lo); arith = 1'b1;
      end
      2, 3: begin
        r = (av - bv - ci) & m; cf = (av - bv - ci) < 0;
        af = ((av & 15) - (bv & 15) - ci) < 0;
        sr = sa - sb - ci; of = (sr > hi) || (sr < lo); arith = 1'b1;
      end
      4: r = av & bv;
      5: r = av | bv;
      6: r = av ^ bv;
      7: begin r = (av * 2) & m; cf = ((av >> (w - 1)) & 1) != 0; of = (((r >> (w - 1)) & 1) != 0) ^ cf; end
      8: begin r = av >> 1; cf = (av & 1) != 0; of = ((av >> (w - 1)) & 1) != 0; end
      9: begin r = (av >> 1) | (av & (1 << (w - 1))); cf = (av & 1) != 0; of = 1'b0; end
      default: upd = 1'b0;
    endcase
    if (upd) begin
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
      exp_flags[0]  = cf;
      exp_flags[2]  = (ones % 2) == 0;
      if (arith) exp_flags[4] = af;
      exp_flags[6]  = (r == 0);
      exp_flags[7]  = ((r >> (w - 1)) & 1) != 0;
      exp_flags[11] = of;
    end
    return r;
  endfunction

  // Called at a falling edge; returns at the next falling edge after checking
  task automatic run_op(input int op, input bit wide, input int a, input int b, input bit c);
    int r;
    string tag;
    op_valid = 1'b1; op_code = 4'(op); op_wide = wide;
    opnd_a = 16'(a); opnd_b = 16'(b); carry_in = c;
    r = model(op, wide, a, b, c);
    @(negedge clk);
    if (op <= 3)      tag = "R3 R4 R5 R6 R7";
    else if (op <= 6) tag = "R8 R5 R6";
    else if (op <= 9) tag = "R9 R5 R6";
    else              tag = "R12";
    chk({tag, " result"}, res_data, 16'(r));
    chk({tag, " flags"}, flags, exp_flags);
  endtask

  task automatic ctl_write(input logic [2:0] wr, input logic [2:0] val);
    op_valid = 1'b0; ctl_wr = wr; ctl_val = val;
    for (int i = 0; i < 3; i++) if (wr[i]) exp_flags[8+i] = val[i];
    @(negedge clk);
    ctl_wr = '0;
    chk("R10 control write", flags, exp_flags);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int edges8 [8]  = '{0, 1, 'h0F, 'h10, 'h7F, 'h80, 'hFE, 'hFF};
    int edges16 [8] = '{0, 1, 'h000F, 'h00FF, 'h7FFF, 'h8000, 'hFFFE, 'hFFFF};
    int r, keep_a;
    repeat (3) @(negedge clk);
    chk("R1 flags at reset", flags, 16'h0002);
    chk("R1 res_valid at reset", {15'd0, res_valid}, 16'h0);
    chk("R1 res_data at reset", res_data, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Byte grid for the four arithmetic codes
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 256; a += 5)
        for (int b = 0; b < 256; b += 3)
          run_op(op, 1'b0, a, b, bit'((a + b) & 1));

    // Boundary pairs, both widths, both carry values
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int c = 0; c < 2; c++) begin
            run_op(op, 1'b0, edges8[i], edges8[j], bit'(c));
            run_op(op, 1'b1, edges16[i], edges16[j], bit'(c));
          end

    // Word pseudo-random
    for (int op = 0; op < 4; op++)
      for (int k = 0; k < 2000; k++)
        run_op(op, 1'b1, int'(rnd() >> 8) & 16'hFFFF, int'(rnd() >> 8) & 16'hFFFF, rnd()[20]);

    // Control flags set, then arithmetic must keep them
    ctl_write(3'b101, 3'b101);
    ctl_write(3'b010, 3'b010);
    run_op(0, 1'b1, 'hFFFF, 1, 1'b0);
    chk("R10 control bits after add", {13'd0, flags[10:8]}, 16'h0007);
    ctl_write(3'b001, 3'b000);

    // Logic and shift with nibble carry left set by an add
    for (int op = 4; op < 10; op++)
      for (int k = 0; k < 600; k++) begin
        if ((k % 50) == 0) run_op(0, 1'b0, 'h0F, 'h01, 1'b0);
        run_op(op, rnd()[17], int'(rnd() >> 8) & 16'hFFFF, int'(rnd() >> 8) & 16'hFFFF, 1'b0);
      end
    run_op(0, 1'b0, 'h08, 'h08, 1'b0);
    chk("R4 nibble carry set", {15'd0, flags[4]}, 16'h1);
    run_op(4, 1'b0, 'hFF, 'h00, 1'b0);
    chk("R8 nibble carry kept after AND", {15'd0, flags[4]}, 16'h1);
    run_op(7, 1'b1, 'h8001, 'h1234, 1'b0);
    chk("R9 shift left carry", {15'd0, flags[0]}, 16'h1);

    // Unused codes
    for (int op = 10; op < 16; op++) begin
      run_op(op, 1'b0, 'hA5C3, 'h1111, 1'b1);
      run_op(op, 1'b1, 'h5A3C, 'h2222, 1'b0);
    end
    chk("R2 fixed bits", flags & 16'hF02A, 16'h0002);

    // Back-pressure
    op_valid = 1'b0; res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    run_op(2, 1'b0, 'h10, 'h20, 1'b0);
    keep_a = exp_flags;
    chk("R11 op_ready low while stalled", {15'd0, op_ready}, 16'h0);
    op_code = 4'd0; opnd_a = 16'h7F; opnd_b = 16'h01; op_wide = 1'b0; op_valid = 1'b1;
    @(negedge clk);
    chk("R11 result held", res_data, 16'h00F0);
    chk("R11 flags held", flags, 16'(keep_a));
    chk("R11 valid held", {15'd0, res_valid}, 16'h1);
    res_ready = 1'b1;
    r = model(0, 1'b0, 'h7F, 'h01, 1'b0);
    @(negedge clk);
    chk("R11 result after drain", res_data, 16'(r));
    chk("R11 flags after drain", flags, exp_flags);
    op_valid = 1'b0;
    @(negedge clk);
    chk("R11 valid drops when idle", {15'd0, res_valid}, 16'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule